// File: doc/BRIEF.md
# Telecom Bus Clock and Frame Pulse Generator

This block turns one free-running core clock into a set of telecom bus clocks and 8 kHz frame pulses. All of them share one frame position counter, so every clock edge and every pulse keeps a fixed phase to the 125 us frame boundary. The core clock runs at 131.072 MHz, which is two ticks per 65.536 MHz master period. This lets a registered output carry a 65.536 MHz square wave, and every pulse width is a whole number of master periods (an even number of core cycles).

Four clocks come out. Two are fixed: 2.048 MHz and 16.384 MHz. The other two are shared outputs whose rate follows the static select input: one carries 4.096 or 65.536 MHz, the other 8.192 or 32.768 MHz. Three frame pulses come out as well. Two of them change width under the same select input. The third is a fixed pulse for the 16.384 MHz domain. The select input is taken once per frame, at the frame midpoint. At that point every pulse is idle and every divided clock has just fallen, so a change never cuts a pulse short or leaves a runt clock.

The frame position is 0 during reset and advances by one per core cycle. It runs 0 to 16383 and then wraps. Position 0 is the first cycle of a frame. In every cycle the outputs show the levels that belong to the current position.

Top module: `tclk_frame_gen`

## Requirements
- R1: While rst_i is high at a rising edge, the next cycle shows all four clocks low, frm_a_n_o and frm_16_n_o high, and frm_b_o low.
- R2: A frame is 16384 core cycles long, and each frame pulse repeats with exactly that period.
- R3: clk_2m_o equals bit 5 of the position (period 64) and clk_16m_o equals bit 2 (period 8), whatever the select input. Both fall in the cycle at position 0.
- R4: clk_mux_a_o equals position bit 4 (period 32, 4.096 MHz) when the effective select is 0, and bit 0 (period 2, 65.536 MHz) when it is 1.
- R5: clk_mux_b_o equals position bit 3 (period 16, 8.192 MHz) when the effective select is 0, and bit 1 (period 4, 32.768 MHz) when it is 1.
- R6: frm_a_n_o is active low, centred on the boundary. With effective select 0 it is low at positions 16368 to 16383 and 0 to 15 (32 cycles). With effective select 1 it is low at positions 16383 and 0 only.
- R7: frm_b_o is active high from position 0. It lasts 16 cycles with effective select 0 and 4 cycles with effective select 1.
- R8: frm_16_n_o is active low at positions 16380 to 16383 and 0 to 3 (8 cycles), whatever the select input.
- R9: The effective select takes the sel_i value present at the edge that moves the position from 8191 to 8192. It also takes sel_i during reset. A change of sel_i at any other time has no effect on any output before the next such edge.
- R10: After reset no frame pulse is active until the first frame boundary, so the first active pulse level appears at position 16368 (effective select 0) of the first frame. The clocks run from the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the master rate |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Static rate and width select |
| clk_2m_o | output | 1 | Fixed 2.048 MHz clock |
| clk_16m_o | output | 1 | Fixed 16.384 MHz clock |
| clk_mux_a_o | output | 1 | 4.096 MHz or 65.536 MHz clock |
| clk_mux_b_o | output | 1 | 8.192 MHz or 32.768 MHz clock |
| frm_a_n_o | output | 1 | Centred active-low frame pulse, wide or narrow |
| frm_b_o | output | 1 | Active-high frame pulse from the boundary, wide or narrow |
| frm_16_n_o | output | 1 | Centred active-low frame pulse for the 16.384 MHz domain |

## Verification
At the frame midpoint, two events fall in one cycle: the select update and the simultaneous falling edge of every divided clock, when the shared outputs swap their source. A request can also arrive while a centred pulse straddles the boundary. The bench provokes the first case by driving sel_i in the cycle just before the midpoint edge, then reversing it one cycle after. It provokes the second by flipping sel_i in the middle of a wide pulse. It judges the results by measured clock periods, by the width and first position of each pulse around the next boundaries, and by a cycle-by-cycle comparison against a position model built from the requirements.

// File: rtl/tclk_pkg.sv
`timescale 1ns/1ps
package tclk_pkg;

    // Number of position bits that the clock outputs are taken from.
    localparam int CLK_BITS = 6;

    // Position bit feeding each clock; bit k gives a period of 2^(k+1) core cycles.
    localparam int BIT_2M     = 5;
    localparam int BIT_16M    = 2;
    localparam int BIT_A_SLOW = 4;
    localparam int BIT_A_FAST = 0;
    localparam int BIT_B_SLOW = 3;
    localparam int BIT_B_FAST = 1;

    // Registered output bundle.
    typedef struct packed {
        logic clk_2m;
        logic clk_16m;
        logic clk_a;
        logic clk_b;
        logic frm_a_n;
        logic frm_b;
        logic frm_16_n;
    } out_t;

    localparam out_t OUT_IDLE = '{
        clk_2m:   1'b0,
        clk_16m:  1'b0,
        clk_a:    1'b0,
        clk_b:    1'b0,
        frm_a_n:  1'b1,
        frm_b:    1'b0,
        frm_16_n: 1'b1
    };

endpackage

// File: rtl/tclk_frame_ctr.sv
`timescale 1ns/1ps
module tclk_frame_ctr #(
    parameter int CNT_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sel_i,
    output logic [CNT_W-1:0] pos_d_o,
    output logic             sel_d_o,
    output logic             armed_d_o
);

    // Last position before the frame midpoint; the select and arm flag load here.
    localparam logic [CNT_W-1:0] MID_PREV = CNT_W'((1 << (CNT_W - 1)) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic             sel;
        logic             armed;
    } ctr_t;

    ctr_t st_d;
    ctr_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pos = st_q.pos + 1'b1;
        if (st_q.pos == MID_PREV) begin
            st_d.sel   = sel_i;
            st_d.armed = 1'b1;
        end
        if (rst_i) begin
            st_d.pos   = '0;
            st_d.sel   = sel_i;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // Next-state values; the top registers its outputs from these.
    assign pos_d_o   = st_d.pos;
    assign sel_d_o   = st_d.sel;
    assign armed_d_o = st_d.armed;

endmodule

// File: rtl/tclk_clk_sel.sv
`timescale 1ns/1ps
module tclk_clk_sel
    import tclk_pkg::*;
(
    input  logic [CLK_BITS-1:0] bits_i,
    input  logic                sel_i,
    output logic                clk_2m_o,
    output logic                clk_16m_o,
    output logic [1:0]          clk_mux_o
);

    // Lane 0 is the 4.096/65.536 output, lane 1 the 8.192/32.768 output.
    localparam int SLOW_BIT [2] = '{BIT_A_SLOW, BIT_B_SLOW};
    localparam int FAST_BIT [2] = '{BIT_A_FAST, BIT_B_FAST};

    assign clk_2m_o  = bits_i[BIT_2M];
    assign clk_16m_o = bits_i[BIT_16M];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign clk_mux_o[g] = sel_i ? bits_i[FAST_BIT[g]] : bits_i[SLOW_BIT[g]];
    end

endmodule

// File: rtl/tclk_pulse_win.sv
`timescale 1ns/1ps
module tclk_pulse_win #(
    parameter int CNT_W   = 14,
    parameter int W0      = 16,
    parameter int W1      = 1,
    parameter bit CENTRED = 1'b1,
    parameter bit ACT_LOW = 1'b1
) (
    input  logic [CNT_W-1:0] pos_i,
    input  logic             sel_i,
    input  logic             armed_i,
    output logic             lvl_o
);

    // Widths are in master periods; one master period is two core cycles.
    localparam logic [CNT_W-1:0] LAST = '1;
    localparam logic [CNT_W-1:0] H0   = CNT_W'(W0);
    localparam logic [CNT_W-1:0] H1   = CNT_W'(W1);

    logic [CNT_W-1:0] half;
    logic             hit;

    always_comb half = sel_i ? H1 : H0;

    if (CENTRED) begin : g_centred
        // Half the width before the wrap and half after it.
        always_comb hit = (pos_i < half) || (pos_i > (LAST - half));
    end else begin : g_leading
        // Full width starting at position 0.
        always_comb hit = (pos_i < {half[CNT_W-2:0], 1'b0});
    end

    always_comb lvl_o = ACT_LOW ? !(armed_i && hit) : (armed_i && hit);

endmodule

// File: rtl/tclk_frame_gen.sv
`timescale 1ns/1ps
module tclk_frame_gen
    import tclk_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int FA_W0 = 16,
    parameter int FA_W1 = 1,
    parameter int FB_W0 = 8,
    parameter int FB_W1 = 2,
    parameter int F16_W = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sel_i,
    output logic clk_2m_o,
    output logic clk_16m_o,
    output logic clk_mux_a_o,
    output logic clk_mux_b_o,
    output logic frm_a_n_o,
    output logic frm_b_o,
    output logic frm_16_n_o
);

    logic [CNT_W-1:0] pos_nxt;
    logic             sel_nxt;
    logic             armed_nxt;

    tclk_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sel_i     (sel_i),
        .pos_d_o   (pos_nxt),
        .sel_d_o   (sel_nxt),
        .armed_d_o (armed_nxt)
    );

    logic       clk2_nxt;
    logic       clk16_nxt;
    logic [1:0] mux_nxt;

    tclk_clk_sel u_clk (
        .bits_i    (pos_nxt[CLK_BITS-1:0]),
        .sel_i     (sel_nxt),
        .clk_2m_o  (clk2_nxt),
        .clk_16m_o (clk16_nxt),
        .clk_mux_o (mux_nxt)
    );

    logic fa_nxt;
    logic fb_nxt;
    logic f16_nxt;

    tclk_pulse_win #(
        .CNT_W(CNT_W), .W0(FA_W0), .W1(FA_W1), .CENTRED(1'b1), .ACT_LOW(1'b1)
    ) u_pulse_a (
        .pos_i (pos_nxt), .sel_i (sel_nxt), .armed_i (armed_nxt), .lvl_o (fa_nxt)
    );

    tclk_pulse_win #(
        .CNT_W(CNT_W), .W0(FB_W0), .W1(FB_W1), .CENTRED(1'b0), .ACT_LOW(1'b0)
    ) u_pulse_b (
        .pos_i (pos_nxt), .sel_i (sel_nxt), .armed_i (armed_nxt), .lvl_o (fb_nxt)
    );

    tclk_pulse_win #(
        .CNT_W(CNT_W), .W0(F16_W), .W1(F16_W), .CENTRED(1'b1), .ACT_LOW(1'b1)
    ) u_pulse_16 (
        .pos_i (pos_nxt), .sel_i (sel_nxt), .armed_i (armed_nxt), .lvl_o (f16_nxt)
    );

    out_t out_d;
    out_t out_q;

    always_comb begin
        out_d.clk_2m   = clk2_nxt;
        out_d.clk_16m  = clk16_nxt;
        out_d.clk_a    = mux_nxt[0];
        out_d.clk_b    = mux_nxt[1];
        out_d.frm_a_n  = fa_nxt;
        out_d.frm_b    = fb_nxt;
        out_d.frm_16_n = f16_nxt;
        if (rst_i) begin
            out_d = OUT_IDLE;
        end
    end

    always_ff @(posedge clk_i) begin
        out_q <= out_d;
    end

    assign clk_2m_o    = out_q.clk_2m;
    assign clk_16m_o   = out_q.clk_16m;
    assign clk_mux_a_o = out_q.clk_a;
    assign clk_mux_b_o = out_q.clk_b;
    assign frm_a_n_o   = out_q.frm_a_n;
    assign frm_b_o     = out_q.frm_b;
    assign frm_16_n_o  = out_q.frm_16_n;

endmodule

// File: rtl/tclk_frame_gen_chk.sv
`timescale 1ns/1ps
module tclk_frame_gen_chk #(
    parameter int CNT_W = 14
) (
    input logic clk_i,
    input logic rst_i,
    input logic clk_2m_o,
    input logic clk_16m_o,
    input logic clk_mux_a_o,
    input logic clk_mux_b_o,
    input logic frm_a_n_o,
    input logic frm_b_o,
    input logic frm_16_n_o
);

    logic [CNT_W-1:0] per_cnt;
    logic             fb_prev;
    logic             seen_rise;
    logic [4:0]       lo_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            per_cnt   <= '0;
            fb_prev   <= 1'b0;
            seen_rise <= 1'b0;
            lo_cnt    <= '0;
        end else begin
            fb_prev <= frm_b_o;
            if (frm_b_o && !fb_prev) begin
                per_cnt   <= '0;
                seen_rise <= 1'b1;
            end else begin
                per_cnt <= per_cnt + 1'b1;
            end
            lo_cnt <= frm_16_n_o ? 5'd0 : lo_cnt + 5'd1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk_i) rst_i |=> (!clk_2m_o && !clk_16m_o && !clk_mux_a_o && !clk_mux_b_o && frm_a_n_o && !frm_b_o && frm_16_n_o)); // R1

    AST_FRAME_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i) (frm_b_o && !fb_prev && seen_rise) |-> (&per_cnt)); // R2

    AST_BOUNDARY_FALL: assert property (@(posedge clk_i) disable iff (rst_i) $rose(frm_b_o) |-> $fell(clk_2m_o)); // R3

    AST_LEAD_PULSE_CLK_LOW: assert property (@(posedge clk_i) disable iff (rst_i) frm_b_o |-> !clk_2m_o); // R7

    AST_FP16_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i) (frm_16_n_o && (lo_cnt != 5'd0)) |-> (lo_cnt == 5'd8)); // R8

endmodule

bind tclk_frame_gen tclk_frame_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .clk_2m_o    (clk_2m_o),
    .clk_16m_o   (clk_16m_o),
    .clk_mux_a_o (clk_mux_a_o),
    .clk_mux_b_o (clk_mux_b_o),
    .frm_a_n_o   (frm_a_n_o),
    .frm_b_o     (frm_b_o),
    .frm_16_n_o  (frm_16_n_o)
);

// File: tb/tclk_frame_gen_bench.sv
`timescale 1ns/1ps
module tclk_frame_gen_bench;

    localparam int FRAME = 16384;
    localparam int MID   = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0;
    logic clk_2m, clk_16m, clk_a, clk_b, fa_n, fb, f16_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    tclk_frame_gen u_tclk_frame_gen (
        .clk_i       (clk),
        .rst_i       (rst),
        .sel_i       (sel),
        .clk_2m_o    (clk_2m),
        .clk_16m_o   (clk_16m),
        .clk_mux_a_o (clk_a),
        .clk_mux_b_o (clk_b),
        .frm_a_n_o   (fa_n),
        .frm_b_o     (fb),
        .frm_16_n_o  (f16_n)
    );

    // Frame position model taken from the requirements.
    int pos = 0;
    bit exp_sel = 1'b0;
    bit exp_armed = 1'b0;
    bit started = 1'b0;
    int mm [7];
    string tag [7] = '{"R3", "R3", "R4", "R5", "R6", "R7", "R8"};

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            pos       <= 0;
            exp_sel   <= sel;
            exp_armed <= 1'b0;
        end else begin
            if (pos == MID - 1) begin
                exp_sel   <= sel;
                exp_armed <= 1'b1;
            end
            pos <= (pos + 1) % FRAME;
        end
    end

    function automatic bit get_sig(int i);
        case (i)
            0: return clk_2m;
            1: return clk_16m;
            2: return clk_a;
            3: return clk_b;
            4: return fa_n;
            5: return fb;
            default: return f16_n;
        endcase
    endfunction

    function automatic bit exp_bit(int i);
        bit [13:0] pb = pos[13:0];
        bit s  = exp_sel;
        bit ar = exp_armed;
        case (i)
            0: return pb[5];
            1: return pb[2];
            2: return s ? pb[0] : pb[4];
            3: return s ? pb[1] : pb[3];
            4: return !(ar && (s ? (pos == FRAME - 1 || pos == 0) : (pos >= FRAME - 16 || pos < 16)));
            5: return ar && (pos < (s ? 4 : 16));
            default: return !(ar && (pos >= FRAME - 4 || pos < 4));
        endcase
    endfunction

    always @(negedge clk) begin
        if (started) begin
            for (int i = 0; i < 7; i++) begin
                if (get_sig(i) !== exp_bit(i)) mm[i]++;
            end
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_pos(int p);
        @(negedge clk);
        while (pos != p) @(negedge clk);
    endtask

    task automatic period(int i, output int p);
        bit prev;
        bit cur;
        prev = get_sig(i);
        @(negedge clk);
        cur = get_sig(i);
        while (!(cur && !prev)) begin prev = cur; @(negedge clk); cur = get_sig(i); end
        p = 0;
        prev = cur;
        @(negedge clk); p++; cur = get_sig(i);
        while (!(cur && !prev)) begin prev = cur; @(negedge clk); p++; cur = get_sig(i); end
    endtask

    // Scan 80 cycles around a boundary; count active cycles and first active position.
    int a_cnt, a_first, b_cnt, b_first, c_cnt, c_first;
    task automatic scan(int flip_pos, bit flip_val);
        a_cnt = 0; b_cnt = 0; c_cnt = 0;
        a_first = -1; b_first = -1; c_first = -1;
        wait_pos(FRAME - 40);
        for (int k = 0; k < 80; k++) begin
            if (k > 0) @(negedge clk);
            if (pos == flip_pos) sel = flip_val;
            if (!fa_n) begin if (a_cnt == 0) a_first = pos; a_cnt++; end
            if (fb)    begin if (b_cnt == 0) b_first = pos; b_cnt++; end
            if (!f16_n) begin if (c_cnt == 0) c_first = pos; c_cnt++; end
        end
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        chk("R1", int'({clk_2m, clk_16m, clk_a, clk_b, fa_n, fb, f16_n}), int'(7'b0000101), "idle levels in reset");
        rst = 1'b0;
    endtask

    task automatic t_first_frame;
        int act = 0;
        while (pos != FRAME - 100) begin
            @(negedge clk);
            if (!fa_n || fb || !f16_n) act++;
        end
        chk("R10", act, 0, "active pulse cycles before first boundary");
        scan(-1, 1'b0);
        chk("R10", a_first, FRAME - 16, "first active pulse position");
        chk("R6", a_cnt, 32, "wide centred pulse width");
        chk("R7", b_cnt, 16, "wide leading pulse width");
        chk("R7", b_first, 0, "leading pulse start");
        chk("R8", c_cnt, 8, "fixed pulse width");
        chk("R8", c_first, FRAME - 4, "fixed pulse start");
    endtask

    task automatic t_periods(bit s);
        int p;
        period(0, p); chk("R3", p, 64, "2.048 MHz period");
        period(1, p); chk("R3", p, 8, "16.384 MHz period");
        period(2, p); chk("R4", p, s ? 2 : 32, "shared clock A period");
        period(3, p); chk("R5", p, s ? 4 : 16, "shared clock B period");
    endtask

    task automatic t_flip_in_pulse;
        scan(FRAME - 10, 1'b1);
        chk("R9", a_cnt, 32, "centred pulse unchanged by mid-pulse select");
        chk("R9", b_cnt, 16, "leading pulse unchanged by mid-pulse select");
        chk("R9", a_first, FRAME - 16, "centred pulse start unchanged");
    endtask

    task automatic t_narrow;
        wait_pos(MID + 100);
        t_periods(1'b1);
        scan(-1, 1'b1);
        chk("R6", a_cnt, 2, "narrow centred pulse width");
        chk("R6", a_first, FRAME - 1, "narrow centred pulse start");
        chk("R7", b_cnt, 4, "narrow leading pulse width");
        chk("R7", b_first, 0, "narrow leading pulse start");
        chk("R8", c_cnt, 8, "fixed pulse width with select high");
    endtask

    task automatic t_frame_period;
        int p;
        period(5, p);
        chk("R2", p, FRAME, "leading pulse repeat period");
    endtask

    task automatic t_mid_edge;
        int p;
        wait_pos(MID - 1);
        sel = 1'b0;
        wait_pos(MID);
        sel = 1'b1;
        wait_pos(MID + 100);
        period(2, p);
        chk("R9", p, 32, "select present at midpoint edge taken");
        scan(-1, 1'b1);
        chk("R9", a_cnt, 32, "late select change ignored until next midpoint");
        chk("R9", b_cnt, 16, "late select change ignored for leading pulse");
        wait_pos(MID + 100);
        period(2, p);
        chk("R9", p, 2, "select taken at following midpoint");
    endtask

    task automatic t_model;
        for (int i = 0; i < 7; i++) begin
            chk(tag[i], mm[i], 0, $sformatf("cycle mismatches on output %0d", i));
        end
    endtask

    initial begin
        t_reset();
        t_first_frame();
        t_periods(1'b0);
        t_flip_in_pulse();
        t_narrow();
        t_frame_period();
        t_mid_edge();
        t_model();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule